// File: doc/BRIEF.md
# Dual-ADC Range Extension Controller

This controller sits behind two ADC channels that are wired to one and the same analog input. It watches the magnitude of each sample from the channel that is currently active and decides which channel feeds the processing chain. It also sets the preamplifier gain of the channel that is not in use, so that this channel is already at the right gain when the controller hands over to it. Gains form a ladder of five steps, and the two channels take alternate steps. Quiet signals climb the ladder toward more gain, after a delay and a settling wait. Loud signals step down the ladder at once, and the handover follows after a settling wait.

The level path is made of a magnitude comparator against a coarse high threshold and a fine low threshold. One shared sample counter acts as timer 1 and as timer 2. A four-state machine runs the handover: WATCH (monitoring), FALL_HOLD (timer 1 on a low level), FALL_SETTLE (timer 2 after the gain pre-set on a low level) and RISE_SETTLE (timer 2 after the gain pre-set on a high level). The transitions are named as follows:
- start_fall: WATCH to FALL_HOLD.
- fall_abort: FALL_HOLD or FALL_SETTLE back to WATCH on recovery.
- fall_preset: FALL_HOLD to FALL_SETTLE.
- fall_direct: FALL_HOLD to WATCH with a switch.
- fall_switch: FALL_SETTLE to WATCH with a switch.
- start_rise: WATCH to RISE_SETTLE with a pre-set.
- rise_abort: RISE_SETTLE back to WATCH.
- rise_switch: RISE_SETTLE to WATCH with a switch.

An optional power-down mode switches off the idle channel between handovers.

Top module: `dual_adc_range_ctrl`

## Requirements
- R1: While `en` is low (and after reset), channel A is active (`sel_b`=0), both gain outputs hold the maximum ladder index and `idle_pwr` is 1; the gains follow a change of the maximum code one cycle later.
- R2: Magnitude is |`smp`| of the 18-bit two's-complement sample. A sample is "high" when the magnitude is above hi×4096+2048 and "low" when it is below lo×1024, where hi is `cfg[15:12]` and lo is `cfg[11:8]`. A magnitude equal to either threshold is neither high nor low. When both conditions hold, high wins.
- R3: A low strobe in WATCH starts timer 1 (start_fall). Any strobe that is not low before expiry returns the block to WATCH (fall_abort) with no change to the gains or to `sel_b`.
- R4: Timer 1 expires on the D1-th strobe after the starting strobe, with every one of them low. At expiry, if the idle gain differs from the active gain index +1, the idle gain is set to that value (fall_preset). On the D2-th further low strobe, `sel_b` toggles (fall_switch).
- R5: A strobe that is not low during FALL_SETTLE, including the strobe on which timer 2 would expire, returns the block to WATCH without a switch. The idle gain keeps its pre-set value.
- R6: If the idle gain already equals the active gain index +1 when timer 1 expires, `sel_b` toggles on that same strobe (fall_direct).
- R7: A high strobe in WATCH sets the idle gain to the active index −1 in that same cycle (start_rise). The switch comes on the D2-th further high strobe (rise_switch). A strobe that is not high before then cancels it (rise_abort).
- R8: No climb happens when the active index equals the maximum level, and no descent happens when it equals the minimum level.
- R9: The timers advance only on cycles with `smp_vld`=1. Dn = (code+1)×256, with the timer-1 code in `cfg[3:0]` and the timer-2 code in `cfg[7:4]`.
- R10: When `cfg[22]`=1 and the block is enabled, `idle_pwr` is 1 only in FALL_SETTLE and RISE_SETTLE. When `cfg[22]`=0, `idle_pwr` is always 1.
- R11: Every switch toggles `sel_b`, and the newly active gain is one index away from the previous active gain. The active channel's gain never changes while that channel stays active.
- R12: Gain index 0..4 means 0, 12, 18, 24 and 30 dB. The maximum level is `cfg[21:20]`+1. The minimum level is `cfg[17:16]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable |
| smp_vld | input | 1 | Sample strobe |
| smp | input | 18 | Signed sample from the active channel |
| cfg | input | 23 | Timer, threshold, gain-limit and power-down fields |
| sel_b | output | 1 | Active channel: 0 = A, 1 = B |
| gain_a | output | 3 | Gain ladder index of channel A |
| gain_b | output | 3 | Gain ladder index of channel B |
| idle_pwr | output | 1 | Power enable of the idle channel |

## Verification
Timer expiry and a change of the level condition can land on the same strobe, and so can timer-1 expiry and the channel switch itself. The bench drives a magnitude exactly one below the low threshold on the strobe that expires timer 1 while the idle gain already matches the target, and expects the switch on that very strobe. It also sends a recovered level on exactly the strobe where timer 2 would end, and expects the old channel to stay active with the pre-set gain held. Threshold-equal magnitudes and full-scale negative samples round out the sweep of the level path.

// File: rtl/rx_pkg.sv
package rx_pkg;
    localparam int GAIN_W   = 3;
    localparam int CODE_W   = 4;
    localparam int CFG_W    = 23;
    localparam logic [GAIN_W-1:0] TOP_LVL = 3'd4;

    typedef enum logic [1:0] {
        ST_WATCH,
        ST_FALL_HOLD,
        ST_FALL_SETTLE,
        ST_RISE_SETTLE
    } rx_state_t;
endpackage

// File: rtl/rx_cfg_decode.sv
module rx_cfg_decode
    import rx_pkg::*;
(
    input  logic [CFG_W-1:0]  cfg,
    output logic [CODE_W-1:0] t1_code,
    output logic [CODE_W-1:0] t2_code,
    output logic [CODE_W-1:0] lo_code,
    output logic [CODE_W-1:0] hi_code,
    output logic [GAIN_W-1:0] min_lvl,
    output logic [GAIN_W-1:0] max_lvl,
    output logic              pd_en
);
    always_comb begin
        t1_code = cfg[3:0];
        t2_code = cfg[7:4];
        lo_code = cfg[11:8];
        hi_code = cfg[15:12];
        min_lvl = GAIN_W'(cfg[17:16]);
        max_lvl = GAIN_W'(cfg[21:20]) + GAIN_W'(1);
        pd_en   = cfg[22];
    end
endmodule

// File: rtl/rx_level.sv
module rx_level #(
    parameter int SAMPLE_W = 18,
    parameter int CODE_W   = 4,
    parameter int HI_SHIFT = 12,
    parameter int HI_OFS   = 2048,
    parameter int LO_SHIFT = 10
) (
    input  logic [SAMPLE_W-1:0] smp,
    input  logic [CODE_W-1:0]   hi_code,
    input  logic [CODE_W-1:0]   lo_code,
    output logic                is_high,
    output logic                is_low
);
    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] hi_thr;
    logic [SAMPLE_W-1:0] lo_thr;

    always_comb begin
        mag     = smp[SAMPLE_W-1] ? (~smp + SAMPLE_W'(1)) : smp;
        hi_thr  = (SAMPLE_W'(hi_code) << HI_SHIFT) + SAMPLE_W'(HI_OFS);
        lo_thr  = SAMPLE_W'(lo_code) << LO_SHIFT;
        is_high = mag > hi_thr;
        is_low  = mag < lo_thr;
    end
endmodule

// File: rtl/rx_timer.sv
module rx_timer #(
    parameter int CODE_W     = 4,
    parameter int TICK_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    localparam int CNT_W = CODE_W + TICK_SHIFT;
    logic [CNT_W-1:0] cnt;

    assign hit = tick && (cnt == {code, {TICK_SHIFT{1'b1}}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || hit)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/dual_adc_range_ctrl.sv
module dual_adc_range_ctrl
    import rx_pkg::*;
#(
    parameter int SAMPLE_W   = 18,
    parameter int TICK_SHIFT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp,
    input  logic [CFG_W-1:0]    cfg,
    output logic                sel_b,
    output logic [GAIN_W-1:0]   gain_a,
    output logic [GAIN_W-1:0]   gain_b,
    output logic                idle_pwr
);
    localparam int NCH = 2;

    logic [CODE_W-1:0] t1_code, t2_code, lo_code, hi_code;
    logic [GAIN_W-1:0] min_lvl, max_lvl;
    logic              pd_en;
    logic              is_high, is_low;

    rx_cfg_decode u_dec (
        .cfg(cfg), .t1_code(t1_code), .t2_code(t2_code), .lo_code(lo_code),
        .hi_code(hi_code), .min_lvl(min_lvl), .max_lvl(max_lvl), .pd_en(pd_en)
    );

    rx_level #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_lvl (
        .smp(smp), .hi_code(hi_code), .lo_code(lo_code),
        .is_high(is_high), .is_low(is_low)
    );

    rx_state_t         state, nxt;
    logic [GAIN_W-1:0] gain_q [NCH];
    logic [GAIN_W-1:0] act_lvl, idl_lvl, up_tgt, dn_tgt, preset_val;
    logic              up_ok, dn_ok, do_preset, do_switch;
    logic              t_tick, t_clr, t_hit;
    logic [CODE_W-1:0] t_code;

    assign t_code = (state == ST_FALL_HOLD) ? t1_code : t2_code;
    assign t_tick = smp_vld && (state != ST_WATCH);
    assign t_clr  = !en || (nxt != state);

    rx_timer #(.CODE_W(CODE_W), .TICK_SHIFT(TICK_SHIFT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(t_clr), .tick(t_tick),
        .code(t_code), .hit(t_hit)
    );

    always_comb begin
        act_lvl = gain_q[sel_b];
        idl_lvl = gain_q[~sel_b];
        up_tgt  = act_lvl + GAIN_W'(1);
        dn_tgt  = act_lvl - GAIN_W'(1);
        up_ok   = act_lvl < max_lvl;
        dn_ok   = act_lvl > min_lvl;
    end

    // next state and handover actions
    always_comb begin
        nxt        = state;
        do_preset  = 1'b0;
        do_switch  = 1'b0;
        preset_val = up_tgt;
        unique case (state)
            ST_WATCH: begin
                if (smp_vld && is_high && dn_ok) begin          // start_rise
                    do_preset  = 1'b1;
                    preset_val = dn_tgt;
                    nxt        = ST_RISE_SETTLE;
                end else if (smp_vld && is_low && up_ok) begin  // start_fall
                    nxt = ST_FALL_HOLD;
                end
            end
            ST_FALL_HOLD: begin
                if (smp_vld && (!is_low || !up_ok)) begin       // fall_abort
                    nxt = ST_WATCH;
                end else if (t_hit) begin
                    if (idl_lvl == up_tgt) begin                // fall_direct
                        do_switch = 1'b1;
                        nxt       = ST_WATCH;
                    end else begin                              // fall_preset
                        do_preset = 1'b1;
                        nxt       = ST_FALL_SETTLE;
                    end
                end
            end
            ST_FALL_SETTLE: begin
                if (smp_vld && !is_low) begin                   // fall_abort
                    nxt = ST_WATCH;
                end else if (t_hit) begin                       // fall_switch
                    do_switch = 1'b1;
                    nxt       = ST_WATCH;
                end
            end
            ST_RISE_SETTLE: begin
                if (smp_vld && !is_high) begin                  // rise_abort
                    nxt = ST_WATCH;
                end else if (t_hit) begin                       // rise_switch
                    do_switch = 1'b1;
                    nxt       = ST_WATCH;
                end
            end
            default: nxt = ST_WATCH;
        endcase
        if (!en) begin
            nxt       = ST_WATCH;
            do_preset = 1'b0;
            do_switch = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WATCH;
        else        state <= nxt;
    end

    // outputs: active select and per-channel gains
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sel_b <= 1'b0;
        else if (!en)       sel_b <= 1'b0;
        else if (do_switch) sel_b <= ~sel_b;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                gain_q[ch] <= TOP_LVL;
            else if (!en)
                gain_q[ch] <= max_lvl;
            else if (do_preset && (sel_b != 1'(ch)))
                gain_q[ch] <= preset_val;
        end
    end

    assign gain_a   = gain_q[0];
    assign gain_b   = gain_q[1];
    assign idle_pwr = !en || !pd_en ||
                      (state == ST_FALL_SETTLE) || (state == ST_RISE_SETTLE);
endmodule

// File: rtl/rx_ctrl_chk.sv
module rx_ctrl_chk
    import rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              smp_vld,
    input logic [CFG_W-1:0]  cfg,
    input logic              sel_b,
    input logic [GAIN_W-1:0] gain_a,
    input logic [GAIN_W-1:0] gain_b,
    input logic              idle_pwr
);
    logic [GAIN_W-1:0] act_g, idl_g;
    assign act_g = sel_b ? gain_b : gain_a;
    assign idl_g = sel_b ? gain_a : gain_b;

    // R1
    dis_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!sel_b && gain_a == gain_b));

    // R9
    switch_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && sel_b != $past(sel_b)) |-> $past(smp_vld));

    // R11
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && sel_b != $past(sel_b)) |->
        (act_g == $past(act_g) + 3'd1 || act_g + 3'd1 == $past(act_g)));

    // R11
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && sel_b == $past(sel_b)) |-> act_g == $past(act_g));

    // R10
    pd_off_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cfg[22]) |-> idle_pwr);

    // R10
    preset_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && sel_b == $past(sel_b) && idl_g != $past(idl_g))
        |-> idle_pwr);

    // R12
    gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_a <= TOP_LVL && gain_b <= TOP_LVL));
endmodule

bind dual_adc_range_ctrl rx_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_vld(smp_vld), .cfg(cfg),
    .sel_b(sel_b), .gain_a(gain_a), .gain_b(gain_b), .idle_pwr(idle_pwr)
);

// File: tb/dual_adc_range_ctrl_test.sv
`timescale 1ns/1ps
module dual_adc_range_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        smp_vld = 1'b0;
    logic [17:0] smp = '0;
    logic [22:0] cfg = '0;
    logic        sel_b, idle_pwr;
    logic [2:0]  gain_a, gain_b;

    int checks = 0;
    int failures = 0;

    localparam int HI_CODE = 2;
    localparam int LO_CODE = 2;
    localparam int HI_THR  = HI_CODE * 4096 + 2048;   // 10240
    localparam int LO_THR  = LO_CODE * 1024;          // 2048
    localparam int D0      = (0 + 1) * 256;
    localparam int D1      = (1 + 1) * 256;
    localparam int BIG     = 20000;
    localparam int SMALL   = 100;
    localparam int MID     = 5000;

    always #2.5 clk = ~clk;

    dual_adc_range_ctrl uut (
        .clk(clk), .rst_n(rst_n), .en(en), .smp_vld(smp_vld), .smp(smp),
        .cfg(cfg), .sel_b(sel_b), .gain_a(gain_a), .gain_b(gain_b),
        .idle_pwr(idle_pwr)
    );

    function automatic logic [22:0] mk(int t1, int t2, int lo, int hi,
                                       int mn, int mx, int pd);
        return {1'(pd), 2'(mx), 2'b00, 2'(mn), 4'(hi), 4'(lo), 4'(t2), 4'(t1)};
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic strobe(int v);
        @(negedge clk);
        smp     <= 18'(v);
        smp_vld <= 1'b1;
        @(negedge clk);
        smp_vld <= 1'b0;
    endtask

    task automatic burst(int v, int n);
        for (int i = 0; i < n; i++) strobe(v);
    endtask

    task automatic rise_switch(int v);
        strobe(v);
        burst(v, D0);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cfg = mk(0, 0, LO_CODE, HI_CODE, 0, 3, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 sel", sel_b, 0);
        check("R1 gain_a", gain_a, 4);
        check("R1 gain_b", gain_b, 4);
        check("R1 pwr", idle_pwr, 1);

        en = 1'b1;
        @(negedge clk);
        check("R10 idle off", idle_pwr, 0);
        strobe(HI_THR);
        check("R2 equal high ignored", gain_b, 4);
        strobe(-(HI_THR + 1));
        check("R7 preset", gain_b, 3);
        check("R10 pwr on preset", idle_pwr, 1);
        check("R7 no switch yet", sel_b, 0);
        burst(BIG, D0 - 1);
        check("R7 before expiry", sel_b, 0);
        repeat (600) @(negedge clk);
        check("R9 no strobes no switch", sel_b, 0);
        strobe(-131072);
        check("R7 switch", sel_b, 1);
        check("R10 idle off after", idle_pwr, 0);

        rise_switch(BIG);
        check("R11 toggle to A", sel_b, 0);
        check("R11 gain_a", gain_a, 2);
        rise_switch(-BIG);
        check("R11 toggle to B", sel_b, 1);
        check("R11 gain_b", gain_b, 1);
        rise_switch(BIG);
        check("R12 lowest index", gain_a, 0);
        burst(BIG, 300);
        check("R8 min clamp sel", sel_b, 0);
        check("R8 min clamp gain_b", gain_b, 1);

        burst(SMALL, 200);
        strobe(LO_THR);
        burst(-SMALL, 200);
        check("R3 abort sel", sel_b, 0);
        check("R3 abort gain_b", gain_b, 1);
        strobe(MID);
        burst(SMALL, D0);
        check("R6 before expiry", sel_b, 0);
        strobe(LO_THR - 1);
        check("R6 direct switch", sel_b, 1);
        check("R6 gain_b", gain_b, 1);

        burst(SMALL, D0 + 1);
        check("R4 preset gain_a", gain_a, 2);
        check("R4 no switch yet", sel_b, 1);
        check("R10 pwr fall settle", idle_pwr, 1);
        burst(SMALL, D0 - 1);
        strobe(MID);
        check("R5 abort on expiry", sel_b, 1);
        check("R5 preset kept", gain_a, 2);
        check("R10 off after abort", idle_pwr, 0);
        burst(SMALL, D0 + 1);
        check("R6 direct after preset", sel_b, 0);

        burst(SMALL, D0 + 1);
        check("R4 preset gain_b", gain_b, 3);
        burst(SMALL, D0);
        check("R4 switch", sel_b, 1);
        burst(SMALL, D0 + 1);
        burst(SMALL, D0);
        check("R4 to top sel", sel_b, 0);
        check("R4 to top gain", gain_a, 4);
        burst(SMALL, 600);
        check("R8 max clamp sel", sel_b, 0);
        check("R8 max clamp gain_b", gain_b, 3);

        strobe(BIG);
        burst(BIG, 100);
        strobe(MID);
        burst(BIG, 200);
        check("R7 abort", sel_b, 0);
        strobe(MID);

        cfg = mk(0, 0, LO_CODE, HI_CODE, 0, 3, 0);
        @(negedge clk);
        check("R10 pd disabled", idle_pwr, 1);

        en = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 dis sel", sel_b, 0);
        check("R1 dis gain_b", gain_b, 4);
        cfg = mk(1, 0, LO_CODE, HI_CODE, 1, 1, 1);
        repeat (2) @(negedge clk);
        check("R12 max code1 a", gain_a, 2);
        check("R12 max code1 b", gain_b, 2);
        en = 1'b1;
        strobe(BIG);
        check("R12 min code1 preset", gain_b, 1);
        burst(BIG, D0);
        check("R12 switch", sel_b, 1);
        burst(BIG, 300);
        check("R8 min code clamp", sel_b, 1);
        check("R8 min gain_a", gain_a, 2);
        burst(SMALL, D1);
        check("R9 timer1 code1 wait", sel_b, 1);
        strobe(SMALL);
        check("R9 timer1 code1 expiry", sel_b, 0);
        burst(SMALL, 600);
        check("R8 max code clamp", sel_b, 0);
        check("R8 max gain", gain_a, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule